// File: doc/BRIEF.md
# RGMII Receive Double-Edge Demultiplexer

This block sits right after the receive pins of a reduced-pin gigabit Ethernet PHY link. A 4-bit data bus and one control line change on both edges of the receive clock. The block turns them into a byte-wide, single-edge stream in the receive clock domain. On the rising edge it takes the low data nibble and the data-valid indication. On the falling edge it takes the high nibble and the error indication. At 1000 Mbps it joins the two captures of one clock period into one byte.

At 10 and 100 Mbps the link sends one nibble per clock. The block then uses only the rising-edge nibble. It joins two consecutive valid nibbles, low nibble first, into one byte, so a byte is presented every second clock. A small two-state machine keeps track of the pairing and restarts it at every frame start. If a frame ends on an odd nibble count, the block drops the leftover nibble and raises a one-cycle alignment-error pulse. A speed-select input picks the mode. Every output is registered on the rising edge, and a synchronous active-high reset clears all state.

Top module: `rxd_ddr_demux`

## Requirements
- R1: While reset is high at a rising edge, the byte, valid, error and alignment outputs are all zero on the next cycle. All capture and pairing state is also cleared.
- R2: With speed_gig high, each clock period whose rising-edge control sample is 1 produces `byte_out = {falling-edge nibble, rising-edge nibble}` with `byte_vld` = 1. This appears one clock after that period's rising edge, and one byte is produced per clock.
- R3: With speed_gig high, `byte_err` is 1 on a valid byte exactly when the falling-edge control sample of that period was 1.
- R4: A period whose rising-edge control sample is 0 and that completes no pair gives `byte_vld` = 0, `byte_err` = 0 and `byte_out` = 0. This holds whatever the falling-edge samples are.
- R5: With speed_gig low, two consecutive valid rising-edge nibbles are joined as {second, first} and strobed once. The strobe comes one clock after the second nibble's period. Falling-edge data nibbles have no effect on the byte.
- R6: With speed_gig low, any period with the valid sample at 0 restarts the pairing. The first valid nibble after it is always taken as a low nibble.
- R7: With speed_gig low, a joined byte carries `byte_err` = 1 when the falling-edge control sample of either of its two periods was 1.
- R8: With speed_gig low, a frame that ends with an unpaired nibble produces no byte for it. It raises `align_err` for exactly one cycle, one clock after the first invalid period.
- R9: `align_err` and `byte_vld` are never high in the same cycle, and `byte_err` is never high without `byte_vld`.
- R10: If speed_gig goes high while a low nibble is held, that nibble is dropped without an alignment pulse. The byte-mode stream continues at once.

State machine: state `PAIR_EMPTY` (no nibble held) and state `PAIR_HELD` (a low nibble waits for its partner). Transitions:
- `take_low`: `PAIR_EMPTY` to `PAIR_HELD`, on a valid nibble in nibble mode.
- `join`: `PAIR_HELD` to `PAIR_EMPTY`, on a valid nibble; the byte is strobed.
- `drop_odd`: `PAIR_HELD` to `PAIR_EMPTY`, on an invalid period; `align_err` is raised.
- `drop_mode`: `PAIR_HELD` to `PAIR_EMPTY`, when speed_gig is high.
- `stay`: `PAIR_EMPTY` to `PAIR_EMPTY`, otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; both edges sample the pins |
| rst | input | 1 | Synchronous active-high reset |
| speed_gig | input | 1 | 1 = byte mode (1000 Mbps), 0 = nibble mode (10/100 Mbps) |
| rxd | input | 4 | Double-edge data nibble from the PHY |
| rxctl | input | 1 | Double-edge control: valid at rise, error at fall |
| byte_out | output | 8 | Rebuilt byte, zero when not valid |
| byte_vld | output | 1 | One-cycle byte strobe |
| byte_err | output | 1 | Receive error flag for the strobed byte |
| align_err | output | 1 | One-cycle pulse for a dropped odd nibble |

## Verification
Two things can fall in the same cycle in nibble mode. One is the alignment pulse for a frame that ended on an odd nibble. The other is the capture of the first nibble of the next frame. The bench provokes this by ending a frame after three nibbles and starting a new one after a single idle period. It checks that the pulse arrives with no strobe, and that the next frame's first byte pairs its own nibbles in low-first order, with no nibble left over from the old frame. A mode switch during a held nibble is the second collision. There, the drop must stay silent while the byte-mode output of the same cycle is still correct.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    // Pairing state of the nibble-mode assembler
    typedef enum logic {
        PAIR_EMPTY = 1'b0,
        PAIR_HELD  = 1'b1
    } pair_st_t;
endpackage

// File: rtl/rxd_edge_cap.sv
module rxd_edge_cap #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] rxd,
    input  logic             rxctl,
    output logic [NIB_W-1:0] rise_nib,
    output logic             rise_dv,
    output logic [NIB_W-1:0] fall_nib,
    output logic             fall_er
);
    // Rising edge: low nibble and data-valid
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_nib <= '0;
            rise_dv  <= 1'b0;
        end else begin
            rise_nib <= rxd;
            rise_dv  <= rxctl;
        end
    end

    // Falling edge: high nibble and error indication
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_nib <= '0;
            fall_er  <= 1'b0;
        end else begin
            fall_nib <= rxd;
            fall_er  <= rxctl;
        end
    end
endmodule

// File: rtl/rxd_pair_fsm.sv
module rxd_pair_fsm
    import rxd_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gig,
    input  logic [NIB_W-1:0]  rise_nib,
    input  logic              rise_dv,
    input  logic [NIB_W-1:0]  fall_nib,
    input  logic              fall_er,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              byte_err,
    output logic              align_err
);
    pair_st_t         state_q, state_d;
    logic [NIB_W-1:0] low_q;
    logic             low_err_q;
    logic             per_err;

    // Error of the period being processed: falling sample during valid
    assign per_err = rise_dv & fall_er;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PAIR_EMPTY: begin
                if (!gig && rise_dv) state_d = PAIR_HELD;   // take_low
            end
            PAIR_HELD: begin
                state_d = PAIR_EMPTY;                       // join / drop_odd / drop_mode
            end
            default: state_d = PAIR_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PAIR_EMPTY;
        else     state_q <= state_d;
    end

    // Output and held-nibble registers
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_out  <= '0;
            byte_vld  <= 1'b0;
            byte_err  <= 1'b0;
            align_err <= 1'b0;
            low_q     <= '0;
            low_err_q <= 1'b0;
        end else begin
            byte_out  <= '0;
            byte_vld  <= 1'b0;
            byte_err  <= 1'b0;
            align_err <= 1'b0;
            if (gig) begin
                if (rise_dv) begin
                    byte_out <= {fall_nib, rise_nib};
                    byte_vld <= 1'b1;
                    byte_err <= per_err;
                end
            end else begin
                unique case (state_q)
                    PAIR_EMPTY: begin
                        if (rise_dv) begin
                            low_q     <= rise_nib;
                            low_err_q <= per_err;
                        end
                    end
                    PAIR_HELD: begin
                        if (rise_dv) begin
                            byte_out <= {rise_nib, low_q};
                            byte_vld <= 1'b1;
                            byte_err <= per_err | low_err_q;
                        end else begin
                            align_err <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxd_ddr_demux.sv
module rxd_ddr_demux #(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              speed_gig,
    input  logic [NIB_W-1:0]  rxd,
    input  logic              rxctl,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              byte_err,
    output logic              align_err
);
    logic [NIB_W-1:0] rise_nib, fall_nib;
    logic             rise_dv, fall_er;

    rxd_edge_cap #(.NIB_W(NIB_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .rxd      (rxd),
        .rxctl    (rxctl),
        .rise_nib (rise_nib),
        .rise_dv  (rise_dv),
        .fall_nib (fall_nib),
        .fall_er  (fall_er)
    );

    rxd_pair_fsm #(.NIB_W(NIB_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .gig       (speed_gig),
        .rise_nib  (rise_nib),
        .rise_dv   (rise_dv),
        .fall_nib  (fall_nib),
        .fall_er   (fall_er),
        .byte_out  (byte_out),
        .byte_vld  (byte_vld),
        .byte_err  (byte_err),
        .align_err (align_err)
    );
endmodule

// File: rtl/rxd_ddr_demux_chk.sv
module rxd_ddr_demux_chk (
    input logic clk,
    input logic rst,
    input logic speed_gig,
    input logic byte_vld,
    input logic byte_err,
    input logic align_err
);
    // R1: outputs quiet in the cycle after a reset edge
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!byte_vld && !byte_err && !align_err));

    // R9: alignment pulse never coincides with a byte strobe
    assert_align_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        align_err |-> !byte_vld);

    // R9: error flag only accompanies a valid byte
    assert_err_needs_vld_R9: assert property (@(posedge clk) disable iff (rst)
        byte_err |-> byte_vld);

    // R8: alignment pulse lasts a single cycle
    assert_align_single_R8: assert property (@(posedge clk) disable iff (rst)
        align_err |=> !align_err);

    // R10: no alignment pulse is produced while in byte mode
    assert_align_nibble_only_R10: assert property (@(posedge clk) disable iff (rst)
        align_err |-> !$past(speed_gig));
endmodule

bind rxd_ddr_demux rxd_ddr_demux_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .speed_gig (speed_gig),
    .byte_vld  (byte_vld),
    .byte_err  (byte_err),
    .align_err (align_err)
);

// File: tb/rxd_ddr_demux_test.sv
module rxd_ddr_demux_test;
    localparam int CLK_PERIOD = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       speed_gig = 1'b1;
    logic [3:0] rxd = '0;
    logic       rxctl = 1'b0;
    logic [7:0] byte_out;
    logic       byte_vld, byte_err, align_err;

    int total = 0;
    int bad = 0;

    // Bench reference state
    logic [3:0] p_lo = '0, p_hi = '0;
    logic       p_dv = 1'b0, p_er = 1'b0;
    logic       m_held = 1'b0;
    logic [3:0] m_lo = '0;
    logic       m_le = 1'b0;
    string      tag_ovr = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_ddr_demux uut (
        .clk       (clk),
        .rst       (rst),
        .speed_gig (speed_gig),
        .rxd       (rxd),
        .rxctl     (rxctl),
        .byte_out  (byte_out),
        .byte_vld  (byte_vld),
        .byte_err  (byte_err),
        .align_err (align_err)
    );

    task automatic chk(input string t, input logic [7:0] eb, input logic ev,
                       input logic ee, input logic ea);
        total++;
        if (byte_out !== eb || byte_vld !== ev || byte_err !== ee || align_err !== ea) begin
            bad++;
            $display("FAIL %s: got byte=%h vld=%b err=%b align=%b exp byte=%h vld=%b err=%b align=%b",
                     t, byte_out, byte_vld, byte_err, align_err, eb, ev, ee, ea);
        end
    endtask

    // One receive clock period: rising nibble lo/dv, falling nibble hi/er
    task automatic step(input logic r, input logic g, input logic [3:0] lo,
                        input logic dv, input logic [3:0] hi, input logic er);
        logic [7:0] eb;
        logic ev, ee, ea;
        string t;
        @(negedge clk); #1;
        rst = r; speed_gig = g; rxd = lo; rxctl = dv;
        @(posedge clk); #1;
        eb = '0; ev = 1'b0; ee = 1'b0; ea = 1'b0;
        if (r) begin
            t = "R1";
            m_held = 1'b0;
        end else if (g) begin
            t = m_held ? "R10" : (p_dv ? (p_er ? "R3" : "R2") : "R4");
            m_held = 1'b0;
            ev = p_dv;
            eb = p_dv ? {p_hi, p_lo} : 8'h00;
            ee = p_dv & p_er;
        end else if (p_dv) begin
            if (!m_held) begin
                m_held = 1'b1; m_lo = p_lo; m_le = p_er;
                t = "R5";
            end else begin
                ev = 1'b1; eb = {p_lo, m_lo}; ee = p_er | m_le;
                m_held = 1'b0;
                t = ee ? "R7" : "R5";
            end
        end else begin
            ea = m_held;
            t = m_held ? "R8 R9" : "R4";
            m_held = 1'b0;
        end
        if (tag_ovr != "" && !r) t = tag_ovr;
        chk(t, eb, ev, ee, ea);
        rxd = hi; rxctl = er;
        if (r) begin
            p_lo = '0; p_hi = '0; p_dv = 1'b0; p_er = 1'b0;
        end else begin
            p_lo = lo; p_hi = hi; p_dv = dv; p_er = er;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1: reset with active pins
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 4'hA, 1'b1, 4'h5, 1'b1);
        step(1'b0, 1'b1, 4'h0, 1'b0, 4'h0, 1'b0);

        // R2/R3: byte mode, every byte value, error on a computed subset
        for (int v = 0; v < 256; v++)
            step(1'b0, 1'b1, v[3:0], 1'b1, v[7:4], v[0] ^ v[5]);
        // R4: idle with noisy falling samples
        for (int v = 0; v < 8; v++)
            step(1'b0, 1'b1, v[3:0], 1'b0, ~v[3:0], v[0]);

        // R5/R7: nibble mode, every byte value, junk on falling nibbles
        for (int v = 0; v < 256; v++) begin
            step(1'b0, 1'b0, v[3:0], 1'b1, ~v[3:0], (v % 7) == 3);
            step(1'b0, 1'b0, v[7:4], 1'b1, v[3:0],  (v % 11) == 5);
        end
        step(1'b0, 1'b0, 4'h0, 1'b0, 4'hF, 1'b1);
        step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0);

        // R8: odd frames of lengths 1, 3 and 5 nibbles
        for (int n = 1; n <= 5; n += 2) begin
            for (int k = 0; k < n; k++)
                step(1'b0, 1'b0, 4'(k + n), 1'b1, 4'h0, 1'b0);
            step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0);
            step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0);
            step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0);
        end

        // R6: odd frame, single idle period, then new frame must pair low-first
        tag_ovr = "R6";
        step(1'b0, 1'b0, 4'h1, 1'b1, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'h2, 1'b1, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'h3, 1'b1, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'hC, 1'b1, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'h9, 1'b1, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0);

        // R10: switch to byte mode while a low nibble is held
        tag_ovr = "R10";
        step(1'b0, 1'b0, 4'h7, 1'b1, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'h4, 1'b1, 4'hE, 1'b0);
        step(1'b0, 1'b1, 4'h6, 1'b1, 4'hB, 1'b1);
        step(1'b0, 1'b1, 4'h0, 1'b0, 4'h0, 1'b0);
        step(1'b0, 1'b1, 4'h0, 1'b0, 4'h0, 1'b0);
        tag_ovr = "";

        // R1: mid-run reset during a held nibble
        step(1'b0, 1'b0, 4'h5, 1'b1, 4'h0, 1'b1);
        step(1'b1, 1'b0, 4'h6, 1'b1, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0);
        step(1'b0, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule